// File: doc/BRIEF.md
# VRAM Rectangle Transfer Sequencer

This block steps a rectangular pixel transfer between a host data stream and a 1024 x 512 frame store of 16-bit pixels. A transfer is armed by one start pulse that carries the corner coordinates, the rectangle extent, the direction and a mask option. After that, every 32-bit data word the host supplies (for writes), or every word it requests (for reads), moves two pixels. The sequencer produces a frame-store address and a strobe for each of the two pixel lanes and keeps its place in raster order from one word to the next.

The rectangle is walked left to right and then top to bottom. A row may end in the middle of a word, and the host may pause between words. The position inside the current row is therefore held across words, and the second lane of a word can fall at the start of the following row. Column and row addresses wrap at the edges of the frame store. The frame store is outside the block: it takes the write strobes, and on a read strobe it returns pixel data combinationally in the same cycle.

Top module: `vram_xfer_seq`

## Requirements
- R1: A start pulse loads the corner from `pos_x` (column, 10 bits) and `pos_y` (row, 9 bits). The first pixel goes to address `{row, column}`, with the row in address bits 18:10 and the column in bits 9:0.
- R2: The width field `size_w` (10 bits) and the height field `size_h` (9 bits) give the extent directly, except that a field value of 0 means 1024 columns or 512 rows.
- R3: In a write transfer, a word presented with `wr_valid` while busy produces, after the next rising edge, a lane-lo write of bits 15:0 to the current pixel and a lane-hi write of bits 31:16 to the pixel that follows it.
- R4: Pixels follow raster order. After the last column of a row the walk resumes at the start column of the next row, and that position carries across words and idle cycles, so an odd width places lane-hi at the start of the next row.
- R5: The column wraps modulo 1024 inside a row, and the row wraps modulo 512 as the walk advances.
- R6: When `mask_set` is high at the start pulse, every pixel written during that transfer has bit 15 forced to 1.
- R7: In a read transfer, `rd_req` while busy raises `pix_re_lo`/`pix_re_hi` with addresses after the next edge. One edge later `rd_valid` is high for one cycle with lane-lo data in bits 15:0 and lane-hi data in bits 31:16. A lane that has no pixel left raises no strobe and returns 0 in its half.
- R8: `busy` is high from the edge after a start until the edge that issues the last pixel. `img_ready` is high over the same span for a read transfer and stays low for a write transfer.
- R9: A data word or read request is ignored when the block is idle or when the transfer runs the other way: no strobe is raised and the position does not move.
- R10: A start pulse while busy abandons the old transfer, begins the new one and sets `abort_err`, which stays set until reset.
- R11: After reset, all strobes, `busy`, `img_ready`, `rd_valid` and `abort_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new transfer |
| start_read | input | 1 | Direction at start: 1 = frame store to host |
| pos_x | input | 10 | Start column |
| pos_y | input | 9 | Start row |
| size_w | input | 10 | Width field, 0 = 1024 |
| size_h | input | 9 | Height field, 0 = 512 |
| mask_set | input | 1 | Force bit 15 of written pixels for this transfer |
| wr_valid | input | 1 | Host write word present |
| wr_data | input | 32 | Host write word, first pixel in the low half |
| rd_req | input | 1 | Host requests one read word |
| rd_pix_lo | input | 16 | Frame-store data for lane lo, same cycle as its strobe |
| rd_pix_hi | input | 16 | Frame-store data for lane hi, same cycle as its strobe |
| rd_valid | output | 1 | Packed read word valid |
| rd_data | output | 32 | Packed read word |
| pix_addr_lo | output | 19 | Lane lo pixel address {row, column} |
| pix_we_lo | output | 1 | Lane lo write strobe |
| pix_re_lo | output | 1 | Lane lo read strobe |
| pix_wdata_lo | output | 16 | Lane lo write pixel |
| pix_addr_hi | output | 19 | Lane hi pixel address {row, column} |
| pix_we_hi | output | 1 | Lane hi write strobe |
| pix_re_hi | output | 1 | Lane hi read strobe |
| pix_wdata_hi | output | 16 | Lane hi write pixel |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read transfer in progress |
| abort_err | output | 1 | Sticky: a transfer was restarted while busy |

## Verification
The pixel strobes, addresses and write data change one rising edge after the word or request that causes them. Packed read data appears one edge after the read strobes, and `busy`/`img_ready` drop on the same edge as the last strobes. The bench drives every input on the falling edge, lets one rising edge pass for strobes (two for read data), and samples on the following falling edge. Expected addresses come from a raster cursor kept in the bench, which is advanced only for lanes that still have pixels left.

// File: rtl/vxs_pkg.sv
package vxs_pkg;

    localparam int XW = 10;            // column address bits (1024 columns)
    localparam int YW = 9;             // row address bits (512 rows)
    localparam int PW = 16;            // pixel width
    localparam int WW = 2 * PW;        // host word width
    localparam int AW = XW + YW;       // pixel address width
    localparam int LANES = WW / PW;

    localparam logic [XW-1:0] X_ONE  = 1;
    localparam logic [XW:0]   XE_ONE = 1;
    localparam logic [YW-1:0] Y_ONE  = 1;
    localparam logic [YW:0]   YE_ONE = 1;

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [XW:0]   w;
    } geom_t;

    typedef struct packed {
        logic [XW-1:0] off;    // column offset inside the current row
        logic [YW-1:0] y;      // current row
        logic [YW:0]   rows;   // rows still to move, 0 = idle
    } cur_t;

    function automatic logic [XW:0] ext_w(input logic [XW-1:0] f);
        return {1'b0, f - X_ONE} + XE_ONE;
    endfunction

    function automatic logic [YW:0] ext_h(input logic [YW-1:0] f);
        return {1'b0, f - Y_ONE} + YE_ONE;
    endfunction

    function automatic cur_t step(input cur_t c, input logic [XW:0] w);
        cur_t n;
        n = c;
        if (({1'b0, c.off} + XE_ONE) == w) begin
            n.off  = '0;
            n.y    = c.y + Y_ONE;
            n.rows = c.rows - YE_ONE;
        end else begin
            n.off  = c.off + X_ONE;
        end
        return n;
    endfunction

    function automatic logic [AW-1:0] pix_addr(input logic [XW-1:0] x0, input cur_t c);
        logic [XW-1:0] col;
        col = x0 + c.off;
        return {c.y, col};
    endfunction

endpackage

// File: rtl/vxs_cursor.sv
module vxs_cursor
    import vxs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_read,
    input  logic          load_mask,
    input  logic [XW-1:0] ld_x,
    input  logic [YW-1:0] ld_y,
    input  logic [XW-1:0] ld_w,
    input  logic [YW-1:0] ld_h,
    input  logic          adv,
    output logic          busy,
    output logic          dir_read,
    output logic          force_msb,
    output logic [1:0]    lane_ok,
    output logic [AW-1:0] addr_lo,
    output logic [AW-1:0] addr_hi,
    output logic          finishing
);
    geom_t g_q;
    cur_t  cur_q, c1, c2;

    always_comb begin
        c1 = step(cur_q, g_q.w);
        c2 = step(c1, g_q.w);
    end

    assign busy       = (cur_q.rows != '0);
    assign lane_ok[0] = busy;
    assign lane_ok[1] = (c1.rows != '0);
    assign addr_lo    = pix_addr(g_q.x0, cur_q);
    assign addr_hi    = pix_addr(g_q.x0, c1);
    assign finishing  = adv && busy && (lane_ok[1] ? (c2.rows == '0) : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q       <= '0;
            cur_q     <= '0;
            dir_read  <= 1'b0;
            force_msb <= 1'b0;
        end else if (load) begin
            g_q.x0     <= ld_x;
            g_q.w      <= ext_w(ld_w);
            cur_q.off  <= '0;
            cur_q.y    <= ld_y;
            cur_q.rows <= ext_h(ld_h);
            dir_read   <= load_read;
            force_msb  <= load_mask;
        end else if (adv && busy) begin
            cur_q <= lane_ok[1] ? c2 : c1;
        end
    end
endmodule

// File: rtl/vxs_lane.sv
module vxs_lane
    import vxs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          do_wr,
    input  logic          force_msb,
    input  logic [AW-1:0] addr_in,
    input  logic [PW-1:0] wdata_in,
    output logic [AW-1:0] addr_q,
    output logic          we_q,
    output logic          re_q,
    output logic [PW-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            we_q <= fire && do_wr;
            re_q <= fire && !do_wr;
            if (fire) begin
                addr_q  <= addr_in;
                wdata_q <= do_wr ? (wdata_in | {force_msb, {(PW-1){1'b0}}}) : '0;
            end
        end
    end
endmodule

// File: rtl/vram_xfer_seq.sv
module vram_xfer_seq
    import vxs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_read,
    input  logic [XW-1:0] pos_x,
    input  logic [YW-1:0] pos_y,
    input  logic [XW-1:0] size_w,
    input  logic [YW-1:0] size_h,
    input  logic          mask_set,
    input  logic          wr_valid,
    input  logic [WW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [PW-1:0] rd_pix_lo,
    input  logic [PW-1:0] rd_pix_hi,
    output logic          rd_valid,
    output logic [WW-1:0] rd_data,
    output logic [AW-1:0] pix_addr_lo,
    output logic          pix_we_lo,
    output logic          pix_re_lo,
    output logic [PW-1:0] pix_wdata_lo,
    output logic [AW-1:0] pix_addr_hi,
    output logic          pix_we_hi,
    output logic          pix_re_hi,
    output logic [PW-1:0] pix_wdata_hi,
    output logic          busy,
    output logic          img_ready,
    output logic          abort_err
);
    logic          dir_read, force_msb, finishing, adv;
    logic [1:0]    lane_ok;
    logic [AW-1:0] cur_addr [LANES];
    logic [AW-1:0] l_addr   [LANES];
    logic [PW-1:0] l_wdata  [LANES];
    logic [PW-1:0] l_rpix   [LANES];
    logic          l_we     [LANES];
    logic          l_re     [LANES];

    vxs_cursor u_cursor (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_read (start_read),
        .load_mask (mask_set),
        .ld_x      (pos_x),
        .ld_y      (pos_y),
        .ld_w      (size_w),
        .ld_h      (size_h),
        .adv       (adv),
        .busy      (busy),
        .dir_read  (dir_read),
        .force_msb (force_msb),
        .lane_ok   (lane_ok),
        .addr_lo   (cur_addr[0]),
        .addr_hi   (cur_addr[1]),
        .finishing (finishing)
    );

    // a start pulse takes precedence over data in the same cycle
    assign adv = busy && !start && (dir_read ? rd_req : wr_valid);

    assign l_rpix[0] = rd_pix_lo;
    assign l_rpix[1] = rd_pix_hi;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vxs_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .fire      (adv && lane_ok[i]),
            .do_wr     (!dir_read),
            .force_msb (force_msb),
            .addr_in   (cur_addr[i]),
            .wdata_in  (wr_data[i*PW +: PW]),
            .addr_q    (l_addr[i]),
            .we_q      (l_we[i]),
            .re_q      (l_re[i]),
            .wdata_q   (l_wdata[i])
        );

        always_ff @(posedge clk) begin
            if (rst)
                rd_data[i*PW +: PW] <= '0;
            else if (l_re[0] || l_re[1])
                rd_data[i*PW +: PW] <= l_re[i] ? l_rpix[i] : '0;
        end
    end

    assign pix_addr_lo  = l_addr[0];
    assign pix_we_lo    = l_we[0];
    assign pix_re_lo    = l_re[0];
    assign pix_wdata_lo = l_wdata[0];
    assign pix_addr_hi  = l_addr[1];
    assign pix_we_hi    = l_we[1];
    assign pix_re_hi    = l_re[1];
    assign pix_wdata_hi = l_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            img_ready <= 1'b0;
            abort_err <= 1'b0;
        end else begin
            rd_valid <= l_re[0] || l_re[1];
            if (start)
                img_ready <= start_read;
            else if (finishing)
                img_ready <= 1'b0;
            if (start && busy)
                abort_err <= 1'b1;
        end
    end
endmodule

// File: rtl/vxs_checker.sv
module vxs_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic wr_valid,
    input logic busy,
    input logic img_ready,
    input logic abort_err,
    input logic rd_valid,
    input logic pix_we_lo,
    input logic pix_re_lo,
    input logic pix_we_hi,
    input logic pix_re_hi
);
    a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    a_r8_img_needs_busy: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> busy);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        abort_err |=> abort_err);

    a_r3_we_from_word: assert property (@(posedge clk) disable iff (rst)
        pix_we_lo |-> $past(wr_valid));

    a_r7_re_then_valid: assert property (@(posedge clk) disable iff (rst)
        (pix_re_lo || pix_re_hi) |=> rd_valid);

    a_r4_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
        (pix_we_hi || pix_re_hi) |-> (pix_we_lo || pix_re_lo));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !(pix_we_lo || pix_re_lo));

    a_r9_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(pix_we_lo && pix_re_lo));
endmodule

bind vram_xfer_seq vxs_checker u_chk (.*);

// File: tb/vram_xfer_seq_test.sv
`timescale 1ns/1ps
module vram_xfer_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, start_read = 1'b0, mask_set = 1'b0;
    logic [9:0]  pos_x = '0, size_w = '0;
    logic [8:0]  pos_y = '0, size_h = '0;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [15:0] rd_pix_lo, rd_pix_hi;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [18:0] pix_addr_lo, pix_addr_hi;
    logic        pix_we_lo, pix_re_lo, pix_we_hi, pix_re_hi;
    logic [15:0] pix_wdata_lo, pix_wdata_hi;
    logic        busy, img_ready, abort_err;

    int n_tests = 0, n_fail = 0;
    int m_x0, m_w, m_off, m_y, m_rows;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] vfun(input logic [18:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign rd_pix_lo = vfun(pix_addr_lo);
    assign rd_pix_hi = vfun(pix_addr_hi);

    vram_xfer_seq uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_addr();
        return (m_y << 10) | ((m_x0 + m_off) % 1024);
    endfunction

    task automatic model_step();
        m_off++;
        if (m_off == m_w) begin
            m_off = 0;
            m_y = (m_y + 1) % 512;
            m_rows--;
        end
    endtask

    task automatic do_start(input int x, input int y, input int wf, input int hf,
                            input logic rd, input logic msk, input string tag);
        @(negedge clk);
        start = 1'b1; start_read = rd; mask_set = msk;
        pos_x = 10'(x); pos_y = 9'(y); size_w = 10'(wf); size_h = 9'(hf);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        m_x0 = x; m_y = y; m_off = 0;
        m_w = (wf == 0) ? 1024 : wf;
        m_rows = (hf == 0) ? 512 : hf;
        chk({tag, " R8 busy after start"}, 32'(busy), 32'd1);
        chk({tag, " R8 img_ready after start"}, 32'(img_ready), 32'(rd));
    endtask

    task automatic write_word(input logic [31:0] d, input logic msk, input string tag);
        logic [15:0] m;
        m = msk ? 16'h8000 : 16'h0000;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        if (m_rows > 0) begin
            chk({tag, " R3 we_lo"}, 32'(pix_we_lo), 32'd1);
            chk({tag, " R4 addr_lo"}, 32'(pix_addr_lo), 32'(exp_addr()));
            chk({tag, " R3 data_lo"}, 32'(pix_wdata_lo), 32'(d[15:0] | m));
            model_step();
        end else chk({tag, " R3 we_lo"}, 32'(pix_we_lo), 32'd0);
        if (m_rows > 0) begin
            chk({tag, " R3 we_hi"}, 32'(pix_we_hi), 32'd1);
            chk({tag, " R4 addr_hi"}, 32'(pix_addr_hi), 32'(exp_addr()));
            chk({tag, " R3 data_hi"}, 32'(pix_wdata_hi), 32'(d[31:16] | m));
            model_step();
        end else chk({tag, " R3 we_hi"}, 32'(pix_we_hi), 32'd0);
        chk({tag, " R8 busy"}, 32'(busy), 32'(m_rows > 0));
    endtask

    task automatic read_word(input string tag);
        logic [31:0] expd;
        expd = '0;
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_req = 1'b0;
        if (m_rows > 0) begin
            chk({tag, " R7 re_lo"}, 32'(pix_re_lo), 32'd1);
            chk({tag, " R7 addr_lo"}, 32'(pix_addr_lo), 32'(exp_addr()));
            expd[15:0] = vfun(19'(exp_addr()));
            model_step();
        end else chk({tag, " R7 re_lo"}, 32'(pix_re_lo), 32'd0);
        if (m_rows > 0) begin
            chk({tag, " R7 re_hi"}, 32'(pix_re_hi), 32'd1);
            chk({tag, " R7 addr_hi"}, 32'(pix_addr_hi), 32'(exp_addr()));
            expd[31:16] = vfun(19'(exp_addr()));
            model_step();
        end else chk({tag, " R7 re_hi"}, 32'(pix_re_hi), 32'd0);
        chk({tag, " R8 busy"}, 32'(busy), 32'(m_rows > 0));
        chk({tag, " R8 img_ready"}, 32'(img_ready), 32'(m_rows > 0));
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R7 rd_valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " R7 rd_data"}, rd_data, expd);
    endtask

    task automatic t_reset();
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 img_ready", 32'(img_ready), 32'd0);
        chk("R11 abort_err", 32'(abort_err), 32'd0);
        chk("R11 rd_valid", 32'(rd_valid), 32'd0);
        chk("R11 strobes", {28'd0, pix_we_lo, pix_we_hi, pix_re_lo, pix_re_hi}, 32'd0);
    endtask

    task automatic t_write_basic();
        do_start(5, 3, 4, 2, 1'b0, 1'b0, "R1 basic");
        for (int i = 0; i < 4; i++) write_word(32'h1111_0000 * (i + 1) + 32'(i), 1'b0, "R1 basic");
    endtask

    task automatic t_odd_width();
        do_start(40, 7, 3, 2, 1'b0, 1'b0, "R4 odd");
        write_word(32'hAAAA_5555, 1'b0, "R4 odd");
        repeat (3) @(negedge clk);
        write_word(32'hBEEF_CAFE, 1'b0, "R4 odd");
        write_word(32'h0F0F_F0F0, 1'b0, "R4 odd");
    endtask

    task automatic t_wrap();
        do_start(1022, 511, 4, 2, 1'b0, 1'b0, "R5 wrap");
        for (int i = 0; i < 4; i++) write_word(32'h0002_0001 + 32'(i), 1'b0, "R5 wrap");
    endtask

    task automatic t_size_zero();
        do_start(0, 100, 0, 1, 1'b0, 1'b0, "R2 width0");
        for (int i = 0; i < 512; i++) write_word(32'(i), 1'b0, "R2 width0");
        do_start(900, 0, 1, 0, 1'b0, 1'b0, "R2 height0");
        for (int i = 0; i < 256; i++) write_word(32'(i) << 8, 1'b0, "R2 height0");
    endtask

    task automatic t_mask();
        do_start(12, 12, 2, 1, 1'b0, 1'b1, "R6 mask");
        write_word(32'h0001_0002, 1'b1, "R6 mask");
        do_start(12, 12, 2, 1, 1'b0, 1'b0, "R6 nomask");
        write_word(32'h0001_0002, 1'b0, "R6 nomask");
    endtask

    task automatic t_read();
        do_start(10, 20, 3, 1, 1'b1, 1'b0, "R7 read");
        read_word("R7 read w1");
        read_word("R7 read w2");
        do_start(1023, 511, 2, 2, 1'b1, 1'b0, "R7 read wrap");
        read_word("R7 rw1");
        read_word("R7 rw2");
    endtask

    task automatic t_ignore();
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 32'h1234_5678; rd_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0;
        chk("R9 idle no strobe", {28'd0, pix_we_lo, pix_we_hi, pix_re_lo, pix_re_hi}, 32'd0);
        do_start(200, 100, 2, 1, 1'b1, 1'b0, "R9 dir");
        @(negedge clk);
        wr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R9 write during read no strobe", {28'd0, pix_we_lo, pix_we_hi, pix_re_lo, pix_re_hi}, 32'd0);
        chk("R9 still busy", 32'(busy), 32'd1);
        read_word("R9 position kept");
    endtask

    task automatic t_abort();
        chk("R10 no err yet", 32'(abort_err), 32'd0);
        do_start(100, 50, 4, 4, 1'b0, 1'b0, "R10 first");
        write_word(32'hDEAD_BEEF, 1'b0, "R10 first");
        do_start(7, 9, 2, 1, 1'b0, 1'b0, "R10 second");
        chk("R10 err set", 32'(abort_err), 32'd1);
        write_word(32'h7777_6666, 1'b0, "R10 second");
        chk("R10 err sticky", 32'(abort_err), 32'd1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R10 err cleared by reset", 32'(abort_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_basic();
        t_odd_width();
        t_wrap();
        t_size_zero();
        t_mask();
        t_read();
        t_ignore();
        t_abort();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule